// File: doc/BRIEF.md
# Translation Fault Interrupt and Flush Controller

This block is the register-mapped control and status unit of an address translator. The table walker reports invalid first-level and second-level entries. The permission checker reports a fault for each requesting master. Each event sets a sticky bit in a status register. An enable register masks those bits, and any bit that is both set and enabled drives a level interrupt. Software clears status bits by writing ones to a separate clear register. For each fault source the block also keeps the faulting address and, depending on the source, the offending table entry or a one-hot record of the master to blame. Only the first fault is captured, so the record software reads belongs to the event that raised the status bit.

The block also holds a flush command register for the translation caches. A written one requests a flush of the walk cache, of the main TLB or of one per-master micro TLB. The bit stays set until that cache returns a completion pulse, so software polls until the whole register reads zero. The translation enable, the automatic clock gating enable and the table base address are plain control registers driven straight out to the translator.

Top module: `xlt_fault_ctl`

## Requirements
- R1: After reset every register reads zero and `irq`, `xlt_on` and `clk_gate_on` are low.
- R2: Bit 0 written at 0x020 drives `xlt_on` and bit 0 written at 0x040 drives `clk_gate_on`. All 32 bits written at 0x050 drive `table_base`. All three read back, and other bits of 0x020 and 0x040 read zero.
- R3: At 0x108 a second-level invalid fault sets bit 17, a first-level invalid fault sets bit 16, and a permission fault of master m sets bit m. The bits stay set until cleared.
- R4: Writing a 1 to a bit of 0x104 clears that status bit, and a 0 leaves it unchanged. A fault that arrives in the same cycle as its clear leaves the bit set. 0x104 reads zero.
- R5: `irq` is high exactly when some status bit is set and its enable bit at 0x100 is set. Only bits 17, 16 and NUM_MASTERS-1:0 of 0x100 are writable, and the rest read zero.
- R6: On a permission fault of master m while status bit m is clear, the fault address is stored at 0x110+4*m and the table entry at 0x150+4*m. Later faults of that master do not change them while the bit stays set.
- R7: On a first-level fault while bit 16 is clear, the address is stored at 0x130 and the one-hot master vector at 0x180. Second-level faults do the same with bit 17, 0x134 and 0x184. Later faults do not change them while the bit stays set.
- R8: A fault that arrives in the same cycle as the write clearing its status bit is captured and replaces the stored address and blame.
- R9: Writing a 1 at 0x080 to bit 17 (walk cache), bit 16 (main TLB) or bit m (micro TLB of master m) sets that flush bit. Written zeros and writes to other bits have no effect.
- R10: A pulse on `flush_done` bit i clears the matching flush bit at the next edge: i<NUM_MASTERS maps to bit i, i=NUM_MASTERS to bit 16 and i=NUM_MASTERS+1 to bit 17. Other pending flush bits are not affected.
- R11: A flush request written in the same cycle as the done pulse of the same target leaves the flush bit set.
- R12: Writes to the status register 0x108 have no effect.
- R13: Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lvl1_fault | input | 1 | Invalid first-level entry pulse from the walker |
| lvl1_va | input | 32 | Address that hit the invalid first-level entry |
| lvl1_src | input | NUM_MASTERS | One-hot master behind the first-level fault |
| lvl2_fault | input | 1 | Invalid second-level entry pulse from the walker |
| lvl2_va | input | 32 | Address that hit the invalid second-level entry |
| lvl2_src | input | NUM_MASTERS | One-hot master behind the second-level fault |
| perm_fault | input | NUM_MASTERS | Per-master permission fault pulses |
| perm_va | input | 32*NUM_MASTERS | Per-master fault addresses, master m in bits 32m+31:32m |
| perm_pte | input | 32*NUM_MASTERS | Per-master offending table entries, same packing |
| flush_done | input | NUM_MASTERS+2 | Flush completion pulses: micro TLBs, then main TLB, then walk cache |
| irq | output | 1 | Level interrupt |
| xlt_on | output | 1 | Translation enable |
| clk_gate_on | output | 1 | Automatic clock gating enable |
| table_base | output | 32 | Table base address |

## Verification
The hardest case to reach is a fault landing in the same cycle as the write that clears its own status bit. Here the status bit must stay set while the capture registers take the new record, and that needs a walker or checker pulse lined up exactly with a register write. The stimulus reaches it two ways. Directed steps place the collision on purpose. A random phase then drives sparse fault pulses on all sources together with random clear masks and enable writes, so collisions on several bits at once occur many times. The flush side is driven with done pulses arriving a fixed latency after the request, staggered by target, plus one done pulse timed on the same edge as a new request.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

   localparam int unsigned XFC_DW = 32;

   localparam int unsigned OFS_XLT_ON  = 32'h020;
   localparam int unsigned OFS_GATE    = 32'h040;
   localparam int unsigned OFS_BASE    = 32'h050;
   localparam int unsigned OFS_FLUSH   = 32'h080;
   localparam int unsigned OFS_IEN     = 32'h100;
   localparam int unsigned OFS_ICLR    = 32'h104;
   localparam int unsigned OFS_ISTA    = 32'h108;
   localparam int unsigned OFS_PVA0    = 32'h110;
   localparam int unsigned OFS_L1VA    = 32'h130;
   localparam int unsigned OFS_L2VA    = 32'h134;
   localparam int unsigned OFS_PPTE0   = 32'h150;
   localparam int unsigned OFS_L1SRC   = 32'h180;
   localparam int unsigned OFS_L2SRC   = 32'h184;

   // bit positions shared by status and flush layouts
   localparam int unsigned BIT_LVL1  = 16;
   localparam int unsigned BIT_LVL2  = 17;
   localparam int unsigned BIT_MAIN  = 16;
   localparam int unsigned BIT_WALK  = 17;

   // writable bits: per-master bits plus the two level bits
   function automatic logic [XFC_DW-1:0] src_mask(int unsigned nm);
      logic [XFC_DW-1:0] r;
      r = '0;
      for (int unsigned i = 0; i < nm; i++) r[i] = 1'b1;
      r[BIT_LVL1] = 1'b1;
      r[BIT_LVL2] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/xfc_sticky.sv
module xfc_sticky #(
   parameter int unsigned     W    = 32,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end
         assign q_o[i] = q;

         // R3 and R11: a set request always lands, even against a clear
         a_r11_set_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
         // R4 and R10: a clear without a competing set drops the bit
         a_r10_clear_drops : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
      end else begin : g_dead
         assign q_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/xfc_capture.sv
module xfc_capture #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  logic         held_i,
   input  logic         release_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] q_o
);

   logic load;
   assign load = fire_i && (!held_i || release_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (load) q_o <= din_i;
   end

   // R6, R7: record of the first fault survives until its status bit is cleared
   a_r6_hold_first : assert property (@(posedge clk) disable iff (!rst_n)
      (held_i && !release_i) |=> $stable(q_o));

   // R8: a fault colliding with its own clear replaces the record
   a_r8_recapture : assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && release_i) |=> (q_o == $past(din_i)));

endmodule

// File: rtl/xlt_fault_ctl.sv
module xlt_fault_ctl
   import xfc_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 6,
   parameter int unsigned ADDR_W      = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic                      lvl1_fault,
   input  logic [31:0]               lvl1_va,
   input  logic [NUM_MASTERS-1:0]    lvl1_src,
   input  logic                      lvl2_fault,
   input  logic [31:0]               lvl2_va,
   input  logic [NUM_MASTERS-1:0]    lvl2_src,
   input  logic [NUM_MASTERS-1:0]    perm_fault,
   input  logic [32*NUM_MASTERS-1:0] perm_va,
   input  logic [32*NUM_MASTERS-1:0] perm_pte,
   input  logic [NUM_MASTERS+1:0]    flush_done,
   output logic                      irq,
   output logic                      xlt_on,
   output logic                      clk_gate_on,
   output logic [31:0]               table_base
);

   localparam int unsigned NM       = NUM_MASTERS;
   localparam logic [31:0] LIVE     = src_mask(NM);
   localparam int unsigned SRC_PAD  = XFC_DW - NM;
   localparam int unsigned LVL_W    = XFC_DW + NM;
   localparam int unsigned PERM_W   = 2 * XFC_DW;

   // elaboration-time parameter checks
   if (NUM_MASTERS < 1 || NUM_MASTERS > 8) begin : g_chk_nm
      $error("NUM_MASTERS must lie in 1..8 to fit the address and bit layout");
   end
   if (ADDR_W < 9 || ADDR_W > 32) begin : g_chk_aw
      $error("ADDR_W must lie in 9..32 to reach the highest register");
   end

   // ---------------- write decode ----------------
   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic wr_xlt, wr_gate, wr_base, wr_flush, wr_ien, wr_iclr;
   assign wr_xlt   = reg_wr && hit(reg_addr, OFS_XLT_ON);
   assign wr_gate  = reg_wr && hit(reg_addr, OFS_GATE);
   assign wr_base  = reg_wr && hit(reg_addr, OFS_BASE);
   assign wr_flush = reg_wr && hit(reg_addr, OFS_FLUSH);
   assign wr_ien   = reg_wr && hit(reg_addr, OFS_IEN);
   assign wr_iclr  = reg_wr && hit(reg_addr, OFS_ICLR);

   // ---------------- control registers ----------------
   logic        xlt_q, gate_q;
   logic [31:0] base_q, ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlt_q  <= 1'b0;
         gate_q <= 1'b0;
         base_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_xlt)  xlt_q  <= reg_wdata[0];
         if (wr_gate) gate_q <= reg_wdata[0];
         if (wr_base) base_q <= reg_wdata;
         if (wr_ien)  ien_q  <= reg_wdata & LIVE;
      end
   end

   assign xlt_on      = xlt_q;
   assign clk_gate_on = gate_q;
   assign table_base  = base_q;

   // ---------------- fault status ----------------
   logic [31:0] ev_vec, clr_vec, sta_q;

   always_comb begin
      ev_vec                = '0;
      ev_vec[NM-1:0]        = perm_fault;
      ev_vec[BIT_LVL1]      = lvl1_fault;
      ev_vec[BIT_LVL2]      = lvl2_fault;
   end

   assign clr_vec = wr_iclr ? (reg_wdata & LIVE) : '0;

   xfc_sticky #(.W(XFC_DW), .MASK(LIVE)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_vec),
      .clr_i (clr_vec),
      .q_o   (sta_q)
   );

   assign irq = |(sta_q & ien_q);

   // ---------------- fault records ----------------
   logic [31:0]       pva_q  [NM];
   logic [31:0]       ppte_q [NM];
   logic [LVL_W-1:0]  l1_rec, l2_rec;

   for (genvar m = 0; m < NM; m++) begin : g_perm
      logic [PERM_W-1:0] rec;
      xfc_capture #(.W(PERM_W)) u_cap (
         .clk       (clk),
         .rst_n     (rst_n),
         .fire_i    (perm_fault[m]),
         .held_i    (sta_q[m]),
         .release_i (clr_vec[m]),
         .din_i     ({perm_pte[m*XFC_DW +: XFC_DW], perm_va[m*XFC_DW +: XFC_DW]}),
         .q_o       (rec)
      );
      assign pva_q[m]  = rec[XFC_DW-1:0];
      assign ppte_q[m] = rec[PERM_W-1:XFC_DW];
   end

   xfc_capture #(.W(LVL_W)) u_cap_l1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (lvl1_fault),
      .held_i    (sta_q[BIT_LVL1]),
      .release_i (clr_vec[BIT_LVL1]),
      .din_i     ({lvl1_src, lvl1_va}),
      .q_o       (l1_rec)
   );

   xfc_capture #(.W(LVL_W)) u_cap_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (lvl2_fault),
      .held_i    (sta_q[BIT_LVL2]),
      .release_i (clr_vec[BIT_LVL2]),
      .din_i     ({lvl2_src, lvl2_va}),
      .q_o       (l2_rec)
   );

   // ---------------- flush command ----------------
   logic [31:0] fset_vec, fdone_vec, flush_q;

   assign fset_vec = wr_flush ? (reg_wdata & LIVE) : '0;

   always_comb begin
      fdone_vec             = '0;
      fdone_vec[NM-1:0]     = flush_done[NM-1:0];
      fdone_vec[BIT_MAIN]   = flush_done[NM];
      fdone_vec[BIT_WALK]   = flush_done[NM+1];
   end

   xfc_sticky #(.W(XFC_DW), .MASK(LIVE)) u_flush (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fset_vec),
      .clr_i (fdone_vec),
      .q_o   (flush_q)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if      (hit(reg_addr, OFS_XLT_ON)) reg_rdata = {31'd0, xlt_q};
      else if (hit(reg_addr, OFS_GATE))   reg_rdata = {31'd0, gate_q};
      else if (hit(reg_addr, OFS_BASE))   reg_rdata = base_q;
      else if (hit(reg_addr, OFS_FLUSH))  reg_rdata = flush_q;
      else if (hit(reg_addr, OFS_IEN))    reg_rdata = ien_q;
      else if (hit(reg_addr, OFS_ISTA))   reg_rdata = sta_q;
      else if (hit(reg_addr, OFS_L1VA))   reg_rdata = l1_rec[XFC_DW-1:0];
      else if (hit(reg_addr, OFS_L2VA))   reg_rdata = l2_rec[XFC_DW-1:0];
      else if (hit(reg_addr, OFS_L1SRC))  reg_rdata = {{SRC_PAD{1'b0}}, l1_rec[LVL_W-1:XFC_DW]};
      else if (hit(reg_addr, OFS_L2SRC))  reg_rdata = {{SRC_PAD{1'b0}}, l2_rec[LVL_W-1:XFC_DW]};
      else begin
         for (int m = 0; m < NM; m++) begin
            if (hit(reg_addr, OFS_PVA0 + 4*m))  reg_rdata = pva_q[m];
            if (hit(reg_addr, OFS_PPTE0 + 4*m)) reg_rdata = ppte_q[m];
         end
      end
   end

   // ---------------- assertions ----------------
   // R2: translation enable follows the written bit 0
   a_r2_xlt_follows : assert property (@(posedge clk) disable iff (!rst_n)
      wr_xlt |=> (xlt_on == $past(reg_wdata[0])));

   // R5: clearing every enable bit silences the interrupt
   a_r5_irq_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && reg_wdata == 32'd0) |=> !irq);

   // R10: done pulse of micro TLB 0 without a new request empties its bit
   a_r10_done0 : assert property (@(posedge clk) disable iff (!rst_n)
      (flush_done[0] && !(wr_flush && reg_wdata[0])) |=> !reg_q_flush0);

   logic reg_q_flush0;
   assign reg_q_flush0 = flush_q[0];

endmodule

// File: tb/xlt_fault_ctl_tb.sv
`timescale 1ns/1ps
module xlt_fault_ctl_tb;

   localparam int NM   = 6;
   localparam int AW   = 12;
   localparam int LAT  = 4;
   localparam logic [31:0] LIVE = 32'h0003_003F;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            lvl1_fault = 1'b0, lvl2_fault = 1'b0;
   logic [31:0]     lvl1_va = '0, lvl2_va = '0;
   logic [NM-1:0]   lvl1_src = '0, lvl2_src = '0;
   logic [NM-1:0]   perm_fault = '0;
   logic [32*NM-1:0] perm_va = '0, perm_pte = '0;
   logic [NM+1:0]   flush_done = '0;
   logic            irq, xlt_on, clk_gate_on;
   logic [31:0]     table_base;

   always #2.5 clk = ~clk;

   xlt_fault_ctl #(.NUM_MASTERS(NM), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lvl1_fault(lvl1_fault), .lvl1_va(lvl1_va), .lvl1_src(lvl1_src),
      .lvl2_fault(lvl2_fault), .lvl2_va(lvl2_va), .lvl2_src(lvl2_src),
      .perm_fault(perm_fault), .perm_va(perm_va), .perm_pte(perm_pte),
      .flush_done(flush_done), .irq(irq), .xlt_on(xlt_on),
      .clk_gate_on(clk_gate_on), .table_base(table_base)
   );

   int tests = 0, fails = 0;
   bit finished = 0;

   // model state for the random phase
   logic [31:0] m_sta = '0, m_en = '0;
   logic [31:0] m_pva [NM], m_ppte [NM];
   logic [31:0] m_l1va = '0, m_l2va = '0, m_l1src = '0, m_l2src = '0;

   function automatic int tgt_bit(int i);
      if (i < NM) return i;
      return (i == NM) ? 16 : 17;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #0.2;
      d = reg_rdata;
   endtask

   task automatic chk_rd(string req, int a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   // one clock edge, then every pulse input returns to idle
   task automatic step();
      @(posedge clk);
      #1;
      reg_wr = 1'b0; lvl1_fault = 1'b0; lvl2_fault = 1'b0;
      perm_fault = '0; flush_done = '0;
   endtask

   task automatic wr(int a, logic [31:0] d);
      reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int m = 0; m < NM; m++) begin m_pva[m] = '0; m_ppte[m] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;

      // R1 reset state
      chk_rd("R1 xlt", 'h020, 0);
      chk_rd("R1 gate", 'h040, 0);
      chk_rd("R1 base", 'h050, 0);
      chk_rd("R1 flush", 'h080, 0);
      chk_rd("R1 ien", 'h100, 0);
      chk_rd("R1 sta", 'h108, 0);
      chk_rd("R1 l1va", 'h130, 0);
      chk_rd("R1 p5pte", 'h164, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 xlt_on", {31'd0, xlt_on}, 0);

      // R2 control registers
      wr('h020, 32'hFFFF_FFFF);
      chk_rd("R2 xlt rb", 'h020, 1);
      chk("R2 xlt_on", {31'd0, xlt_on}, 1);
      wr('h040, 32'h0000_0005);
      chk_rd("R2 gate rb", 'h040, 1);
      chk("R2 clk_gate_on", {31'd0, clk_gate_on}, 1);
      wr('h050, 32'hA5C3_1000);
      chk_rd("R2 base rb", 'h050, 32'hA5C3_1000);
      chk("R2 table_base", table_base, 32'hA5C3_1000);
      wr('h020, 32'h0000_0002);
      chk("R2 xlt off", {31'd0, xlt_on}, 0);

      // R13 unmapped and R4 clear register reads zero
      chk_rd("R13 hole", 'h0FC, 0);
      chk_rd("R13 hole2", 'h1F0, 0);
      chk_rd("R4 clr reads 0", 'h104, 0);

      // random phase against the bench model (R3 R4 R5 R6 R7 R8)
      for (int c = 0; c < 500; c++) begin
         logic [31:0] ev, clr, v;
         int op;
         ev = '0; clr = '0;
         if ($urandom % 6 == 0) begin
            lvl1_fault = 1'b1; lvl1_va = $urandom;
            lvl1_src = NM'(1) << ($urandom % NM); ev[16] = 1'b1;
         end
         if ($urandom % 6 == 0) begin
            lvl2_fault = 1'b1; lvl2_va = $urandom;
            lvl2_src = NM'(1) << ($urandom % NM); ev[17] = 1'b1;
         end
         for (int m = 0; m < NM; m++) begin
            perm_va[m*32 +: 32] = $urandom;
            perm_pte[m*32 +: 32] = $urandom;
            if ($urandom % 7 == 0) begin perm_fault[m] = 1'b1; ev[m] = 1'b1; end
         end
         op = $urandom % 8;
         v = $urandom;
         if (op < 3) begin
            reg_addr = AW'('h104); reg_wdata = v; reg_wr = 1'b1; clr = v & LIVE;
         end else if (op == 3) begin
            reg_addr = AW'('h100); reg_wdata = v; reg_wr = 1'b1;
         end
         // model of the coming edge
         if (ev[16] && (!m_sta[16] || clr[16])) begin m_l1va = lvl1_va; m_l1src = 32'(lvl1_src); end
         if (ev[17] && (!m_sta[17] || clr[17])) begin m_l2va = lvl2_va; m_l2src = 32'(lvl2_src); end
         for (int m = 0; m < NM; m++)
            if (ev[m] && (!m_sta[m] || clr[m])) begin
               m_pva[m] = perm_va[m*32 +: 32]; m_ppte[m] = perm_pte[m*32 +: 32];
            end
         m_sta = (m_sta & ~clr) | ev;
         if (op == 3) m_en = v & LIVE;
         step();
         chk_rd("R3/R4 status", 'h108, m_sta);
         chk("R5 irq", {31'd0, irq}, {31'd0, |(m_sta & m_en)});
         begin
            int m;
            m = $urandom % NM;
            chk_rd("R6/R8 perm va", 'h110 + 4*m, m_pva[m]);
            chk_rd("R6/R8 perm pte", 'h150 + 4*m, m_ppte[m]);
         end
         chk_rd("R7/R8 l1 va", 'h130, m_l1va);
         chk_rd("R7 l1 src", 'h180, m_l1src);
         chk_rd("R7/R8 l2 va", 'h134, m_l2va);
         chk_rd("R7 l2 src", 'h184, m_l2src);
      end

      // directed status corner cases
      wr('h104, 32'hFFFF_FFFF);
      chk_rd("R4 all cleared", 'h108, 0);
      wr('h100, 32'hFFFF_FFFF);
      chk_rd("R5 enable bits", 'h100, LIVE);
      lvl2_fault = 1'b1; lvl2_va = 32'h1234_5000; lvl2_src = 6'b000100;
      step();
      chk_rd("R3 lvl2 bit17", 'h108, 32'h0002_0000);
      chk_rd("R7 l2 va", 'h134, 32'h1234_5000);
      chk_rd("R7 l2 src", 'h184, 32'h0000_0004);
      chk("R5 irq on", {31'd0, irq}, 1);
      lvl2_fault = 1'b1; lvl2_va = 32'hDEAD_0000; lvl2_src = 6'b100000;
      step();
      chk_rd("R7 l2 va held", 'h134, 32'h1234_5000);
      chk_rd("R7 l2 src held", 'h184, 32'h0000_0004);
      // clear bit 17 while a lvl1 fault arrives
      reg_addr = AW'('h104); reg_wdata = 32'h0002_0000; reg_wr = 1'b1;
      lvl1_fault = 1'b1; lvl1_va = 32'h0000_7000; lvl1_src = 6'b000001;
      step();
      chk_rd("R3 lvl1 bit16", 'h108, 32'h0001_0000);
      wr('h104, 32'h0);
      chk_rd("R4 zero write", 'h108, 32'h0001_0000);
      wr('h108, 32'h0);
      chk_rd("R12 sta readonly", 'h108, 32'h0001_0000);
      // R8: same-cycle clear and new fault
      reg_addr = AW'('h104); reg_wdata = 32'h0001_0000; reg_wr = 1'b1;
      lvl1_fault = 1'b1; lvl1_va = 32'hBEEF_1000; lvl1_src = 6'b010000;
      step();
      chk_rd("R4 event wins", 'h108, 32'h0001_0000);
      chk_rd("R8 l1 recapture", 'h130, 32'hBEEF_1000);
      chk_rd("R8 l1 src recapture", 'h180, 32'h0000_0010);
      // R5 masked
      wr('h100, 32'h0);
      chk("R5 irq masked", {31'd0, irq}, 0);
      perm_fault = 6'b001000; perm_va[3*32 +: 32] = 32'h0042_0000; perm_pte[3*32 +: 32] = 32'h0000_0032;
      step();
      chk_rd("R3 perm bit3", 'h108, 32'h0001_0008);
      chk("R5 irq still masked", {31'd0, irq}, 0);
      chk_rd("R6 perm va3", 'h11C, 32'h0042_0000);
      chk_rd("R6 perm pte3", 'h15C, 32'h0000_0032);
      wr('h100, 32'h0000_0008);
      chk("R5 irq per bit", {31'd0, irq}, 1);

      // flush: all targets, done after LAT+i cycles (R9 R10)
      wr('h080, 32'hFFFF_FFFF);
      chk_rd("R9 flush set", 'h080, LIVE);
      begin
         logic [31:0] exp;
         exp = LIVE;
         for (int c = 1; c <= LAT + NM + 1; c++) begin
            for (int i = 0; i < NM + 2; i++)
               if (c == LAT + i) begin flush_done[i] = 1'b1; exp[tgt_bit(i)] = 1'b0; end
            step();
            chk_rd("R10 flush progress", 'h080, exp);
         end
      end
      chk_rd("R10 flush empty", 'h080, 0);
      wr('h080, 32'h0001_0001);
      wr('h080, 32'h0);
      chk_rd("R9 zero write", 'h080, 32'h0001_0001);
      flush_done[NM] = 1'b1;
      step();
      chk_rd("R10 main done", 'h080, 32'h0000_0001);
      // R11: request and done of the same target together
      reg_addr = AW'('h080); reg_wdata = 32'h0000_0001; reg_wr = 1'b1; flush_done[0] = 1'b1;
      step();
      chk_rd("R11 set wins", 'h080, 32'h0000_0001);
      flush_done[0] = 1'b1;
      step();
      chk_rd("R10 micro0 done", 'h080, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule